// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block collects up to 32 interrupt sources and drives one interrupt request line to a processor. Each source carries a 3-bit priority, an enable bit, a trigger mode and a handler address. Software reads a vector location to get the handler address of the most urgent pending source. That read also records the level now in service on a small hardware stack. A write to the end-of-service location removes the newest stack entry, so nested handlers can be interrupted only by strictly more urgent sources.

When the vector location is read and no source qualifies, the read returns a programmable spurious address instead of a handler address. A separate fast-interrupt output only copies its own dedicated input, delayed by one register. Software reaches the block through a plain synchronous register port. Read data appears one cycle after the read strobe.

Register map (word addresses): 0..31 source mode, with bits [2:0] priority, bit 3 edge (1) or level (0), and bit 4 inverted sense (low level or falling edge). 32..63 hold the source handler addresses. 64 is the vector read, 65 the end-of-service write. 66 sets enables when written and returns the enable mask when read. 67 clears enables. 68 holds the spurious address.

Top module: `prio_vic`

## Requirements
- R1: After reset, irq_o and fiq_o are low, all enables and mode registers read 0 and the nesting stack is empty.
- R2: A level source (mode bit 3 = 0) is pending while its input is at the active level, high or (external, bit 4 = 1) low. A vector read does not clear it.
- R3: An edge source (bit 3 = 1) becomes pending on a rising edge, or on a falling edge for an external source with bit 4 = 1. It stays pending after the input returns, until a vector read selects it.
- R4: Sources not marked external in parameter EXT_MASK ignore mode bit 4 and always use high level or rising edge.
- R5: A source whose enable bit is clear neither raises irq_o nor wins the vector read. Bits written as 1 to address 66 set enables, and bits written as 1 to address 67 clear them.
- R6: A vector read returns the handler address of the enabled pending source with the highest priority (7 highest). On a tie, the lowest source number wins.
- R7: A successful vector read pushes the winner's priority. While the stack is non-empty, irq_o is asserted only for a pending source whose priority is strictly above the top entry.
- R8: A write to address 65 pops one stack entry. On an empty stack it has no effect.
- R9: A vector read with no qualifying source returns the spurious address. It pushes a copy of the top entry when the stack is non-empty, and pushes nothing when the stack is empty.
- R10: fiq_o equals fiq_i delayed by one clock and depends on nothing else.
- R11: The stack holds 8 entries, and a push onto a full stack is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| src_i | input | 32 | interrupt source inputs |
| fiq_i | input | 1 | dedicated fast-interrupt input |
| rd_en | input | 1 | register read strobe |
| wr_en | input | 1 | register write strobe |
| addr | input | 7 | word address |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data, valid the cycle after rd_en |
| irq_o | output | 1 | interrupt request to processor |
| fiq_o | output | 1 | fast interrupt request |

## Verification
A wrong stack depth or a stale top entry shows up on irq_o only at the end of a nesting sequence. The request then reappears one end-of-service write too early or too late. The stimulus therefore counts end-of-service writes against a known depth. A wrong winner, or an edge flag left set, shows up on rdata at the next vector read. It can also show as irq_o staying high in the cycle right after the read, so each vector read is followed by an immediate irq_o sample.

// File: rtl/prio_vic_pkg.sv
// Package: shared mode type and register address map of the interrupt controller.
package prio_vic_pkg;
    localparam int PRIO_W = 3;

    // Per-source mode word: sense inversion, edge/level and priority.
    typedef struct packed {
        logic              inv;
        logic              edge_mode;
        logic [PRIO_W-1:0] prio;
    } src_mode_t;

    localparam int MODE_W = $bits(src_mode_t);

    // Control locations within the third address quarter.
    localparam logic [4:0] C_VEC   = 5'd0;
    localparam logic [4:0] C_EOS   = 5'd1;
    localparam logic [4:0] C_ENSET = 5'd2;
    localparam logic [4:0] C_ENCLR = 5'd3;
    localparam logic [4:0] C_SPUR  = 5'd4;
endpackage

// File: rtl/vic_src_cell.sv
// Module: per-source trigger logic.
// Registers the raw input twice, applies the optional inversion (external
// sources only) and produces a pending flag: the active level directly, or a
// sticky edge flag cleared by an acknowledge. Assumes inputs are synchronous.
module vic_src_cell
    import prio_vic_pkg::*;
#(
    parameter bit IS_EXT = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      raw_i,
    input  src_mode_t mode_i,
    input  logic      ack_i,
    output logic      pend_o
);
    logic src_q, src_qq, edge_pend;
    logic pol, act_q, act_qq, edge_hit;

    assign pol      = IS_EXT & mode_i.inv;
    assign act_q    = src_q ^ pol;
    assign act_qq   = src_qq ^ pol;
    assign edge_hit = act_q & ~act_qq;

    // Input history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= 1'b0;
            src_qq <= 1'b0;
        end else begin
            src_q  <= raw_i;
            src_qq <= src_q;
        end
    end

    // Sticky edge flag: set on edge, cleared on acknowledge, idle in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                edge_pend <= 1'b0;
        else if (!mode_i.edge_mode) edge_pend <= 1'b0;
        else if (edge_hit)          edge_pend <= 1'b1;
        else if (ack_i)             edge_pend <= 1'b0;
    end

    assign pend_o = mode_i.edge_mode ? edge_pend : act_q;

    // R3: an acknowledged edge without a new edge leaves nothing pending.
    assert_edge_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i.edge_mode && ack_i && !edge_hit) |=> (!pend_o || !mode_i.edge_mode || $past(mode_i) != mode_i));
endmodule

// File: rtl/vic_arbiter.sv
// Module: priority selector.
// Picks the pending source with the highest priority, lowest index on a tie.
// Purely combinational; assumes pend_i is already masked by the enables.
module vic_arbiter
    import prio_vic_pkg::*;
#(
    parameter int N     = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]             pend_i,
    input  logic [N-1:0][PRIO_W-1:0] prio_i,
    output logic                     any_o,
    output logic [IDX_W-1:0]         idx_o,
    output logic [PRIO_W-1:0]        prio_o
);
    // Linear scan; a strict compare keeps the lower index on ties.
    always_comb begin
        any_o  = 1'b0;
        idx_o  = '0;
        prio_o = '0;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i] && (!any_o || prio_i[i] > prio_o)) begin
                any_o  = 1'b1;
                idx_o  = IDX_W'(i);
                prio_o = prio_i[i];
            end
        end
    end

    // R6: no pending source beats the selected one.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (pend_i[i]) begin
                assert_arb_win_R6: assert (any_o && (prio_i[i] < prio_o ||
                    (prio_i[i] == prio_o && IDX_W'(i) >= idx_o)));
            end
        end
    end
endmodule

// File: rtl/vic_level_stack.sv
// Module: nesting stack of in-service priority levels.
// Push on a vector read, pop on end-of-service. Pops on empty and pushes on
// full are dropped; a simultaneous push and pop replaces the top entry.
module vic_level_stack
    import prio_vic_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [PRIO_W-1:0] push_val_i,
    input  logic              pop_i,
    output logic              empty_o,
    output logic [PRIO_W-1:0] top_o,
    output logic [CNT_W-1:0]  depth_o
);
    logic [DEPTH-1:0][PRIO_W-1:0] stk;
    logic [CNT_W-1:0]             cnt;
    logic                         full;

    assign empty_o = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign top_o   = empty_o ? '0 : stk[cnt - 1'b1];
    assign depth_o = cnt;

    // Stack storage and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            stk <= '0;
        end else if (push_i && pop_i && !empty_o) begin
            stk[cnt - 1'b1] <= push_val_i;
        end else if (push_i && !full) begin
            stk[cnt] <= push_val_i;
            cnt      <= cnt + 1'b1;
        end else if (pop_i && !push_i && !empty_o) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R8: popping an empty stack leaves it empty.
    assert_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> empty_o);
    // R11: a push on a full stack keeps the depth at its limit.
    assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full) |=> (cnt == CNT_W'(DEPTH)));
    // R11: occupancy moves by at most one per cycle.
    assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/prio_vic.sv
// Module: vectored interrupt controller top.
// Holds the per-source mode and vector registers, enables and spurious
// vector; decodes the register port; drives irq_o from the arbiter result
// and the nesting stack top. Assumes one access per cycle at most.
module prio_vic
    import prio_vic_pkg::*;
#(
    parameter int          N        = 32,
    parameter int          DEPTH    = 8,
    parameter int          DATA_W   = 32,
    parameter logic [N-1:0] EXT_MASK = 32'hF000_0000,
    localparam int         IDX_W    = $clog2(N),
    localparam int         ADDR_W   = IDX_W + 2,
    localparam int         CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      src_i,
    input  logic              fiq_i,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    src_mode_t                 mode_r [N];
    logic [DATA_W-1:0]         vec_r  [N];
    logic [N-1:0]              en_r;
    logic [DATA_W-1:0]         spur_r;
    logic [N-1:0]              pend, ack;
    logic [N-1:0][PRIO_W-1:0]  prio_v;
    logic                      any_win;
    logic [IDX_W-1:0]          win_idx;
    logic [PRIO_W-1:0]         win_prio, top_lvl;
    logic                      stk_empty, vec_rd, take, push, pop;
    logic [PRIO_W-1:0]         push_val;
    logic [CNT_W-1:0]          depth;
    logic [1:0]                region;
    logic [IDX_W-1:0]          sel;

    assign region = addr[ADDR_W-1 -: 2];
    assign sel    = addr[IDX_W-1:0];

    // Per-source trigger cells.
    for (genvar g = 0; g < N; g++) begin : g_src
        vic_src_cell #(.IS_EXT(EXT_MASK[g])) u_cell (
            .clk(clk), .rst_n(rst_n), .raw_i(src_i[g]), .mode_i(mode_r[g]),
            .ack_i(ack[g]), .pend_o(pend[g]));
        assign prio_v[g] = mode_r[g].prio;
        assign ack[g]    = take && (win_idx == IDX_W'(g));
    end

    vic_arbiter #(.N(N)) u_arb (
        .pend_i(pend & en_r), .prio_i(prio_v),
        .any_o(any_win), .idx_o(win_idx), .prio_o(win_prio));

    vic_level_stack #(.DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .push_i(push), .push_val_i(push_val),
        .pop_i(pop), .empty_o(stk_empty), .top_o(top_lvl), .depth_o(depth));

    assign irq_o    = any_win && (stk_empty || win_prio > top_lvl);
    assign vec_rd   = rd_en && region == 2'd2 && sel == IDX_W'(C_VEC);
    assign take     = vec_rd && irq_o;
    assign push     = vec_rd && (take || !stk_empty);
    assign push_val = take ? win_prio : top_lvl;
    assign pop      = wr_en && region == 2'd2 && sel == IDX_W'(C_EOS);

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                mode_r[i] <= '0;
                vec_r[i]  <= '0;
            end
            en_r   <= '0;
            spur_r <= '0;
        end else if (wr_en) begin
            unique case (region)
                2'd0: mode_r[sel] <= src_mode_t'(wdata[MODE_W-1:0]);
                2'd1: vec_r[sel]  <= wdata;
                2'd2: begin
                    if (sel == IDX_W'(C_ENSET)) en_r <= en_r | wdata[N-1:0];
                    if (sel == IDX_W'(C_ENCLR)) en_r <= en_r & ~wdata[N-1:0];
                    if (sel == IDX_W'(C_SPUR))  spur_r <= wdata;
                end
                default: ;
            endcase
        end
    end

    // Registered read data, including the vector/spurious return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            unique case (region)
                2'd0: rdata <= DATA_W'(mode_r[sel]);
                2'd1: rdata <= vec_r[sel];
                2'd2: begin
                    if (sel == IDX_W'(C_VEC))        rdata <= take ? vec_r[win_idx] : spur_r;
                    else if (sel == IDX_W'(C_ENSET)) rdata <= DATA_W'(en_r);
                    else if (sel == IDX_W'(C_SPUR))  rdata <= spur_r;
                    else                             rdata <= '0;
                end
                default: rdata <= '0;
            endcase
        end
    end

    // Fast interrupt passes through one register.
    always_ff @(posedge clk) begin
        if (!rst_n) fiq_o <= 1'b0;
        else        fiq_o <= fiq_i;
    end

    // R10: fast output is the dedicated input one cycle later.
    assert_fiq_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_o == $past(fiq_i)));
    // R7: a granted vector read grows the stack unless it was full.
    assert_vec_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !pop && depth != CNT_W'(DEPTH)) |=> (depth == $past(depth) + 1'b1));
    // R9: a spurious read on an empty stack pushes nothing.
    assert_spur_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !take && stk_empty && !pop) |=> stk_empty);
    // R8: end-of-service on a non-empty stack shrinks it by one.
    assert_eos_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !vec_rd && !stk_empty) |=> (depth == $past(depth) - 1'b1));
endmodule

// File: tb/prio_vic_test.sv
// Bench: scoreboard of expected read data plus direct irq/fiq checks.
module prio_vic_test;
    localparam int N = 32;
    localparam logic [6:0] A_VEC = 7'd64, A_EOS = 7'd65, A_ENS = 7'd66,
                           A_ENC = 7'd67, A_SPR = 7'd68;
    localparam logic [31:0] SPUR = 32'h0000_DEAD;

    logic        clk = 1'b0, rst_n = 1'b0, fiq_i = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [N-1:0] src_i = '0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        irq_o, fiq_o;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    prio_vic uut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .fiq_i(fiq_i),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o));

    function automatic logic [31:0] vaddr(int i);
        return 32'h1000 + 32'(i) * 16;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // Driver: issue a read and queue its expected data.
    task automatic rd(logic [6:0] a, logic [31:0] exp, string tag);
        @(negedge clk); rd_en = 1'b1; addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: note read strobes at the edge, compare data at the next negedge.
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    initial begin
        cyc(3); rst_n = 1'b1; cyc(1);
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 fiq", 32'(fiq_o), 0);
        rd(A_ENS, 0, "R1 enables");
        rd(7'd5, 0, "R1 mode");
        for (int i = 0; i < N; i++) wr(7'(32 + i), vaddr(i));
        wr(A_SPR, SPUR);

        // R2 level high, stays pending after read
        wr(7'd3, 32'd2); wr(A_ENS, 32'h8);
        src_i[3] = 1'b1; cyc(2);
        chk("R2 level raise", 32'(irq_o), 1);
        rd(A_VEC, vaddr(3), "R2 vec");
        chk("R7 same level masked", 32'(irq_o), 0);
        wr(A_EOS, 0);
        chk("R2 level still pending", 32'(irq_o), 1);
        rd(A_VEC, vaddr(3), "R2 vec again");
        wr(A_EOS, 0); src_i[3] = 1'b0; cyc(2);
        chk("R2 level drop", 32'(irq_o), 0);

        // R5 masking, R9 spurious on empty, R8 empty pop
        wr(7'd5, 32'd6); src_i[5] = 1'b1; cyc(2);
        chk("R5 disabled no irq", 32'(irq_o), 0);
        rd(A_VEC, SPUR, "R9 spurious empty");
        wr(A_EOS, 0);
        wr(A_ENS, 32'h20);
        chk("R8 R9 empty stack irq", 32'(irq_o), 1);
        wr(A_ENC, 32'h20);
        chk("R5 cleared", 32'(irq_o), 0);
        src_i[5] = 1'b0;

        // R6 arbitration, R7 nesting
        wr(7'd7, 32'd4); wr(7'd2, 32'd4); wr(7'd10, 32'd1); wr(7'd12, 32'd6);
        wr(A_ENS, 32'h1484);
        src_i[7] = 1'b1; src_i[2] = 1'b1; src_i[10] = 1'b1; cyc(2);
        rd(A_VEC, vaddr(2), "R6 tie lowest idx");
        chk("R7 lower masked", 32'(irq_o), 0);
        src_i[12] = 1'b1; cyc(2);
        chk("R7 higher nests", 32'(irq_o), 1);
        rd(A_VEC, vaddr(12), "R6 highest prio");
        src_i[12] = 1'b0; cyc(2);
        wr(A_EOS, 0);
        chk("R8 pop to level 4", 32'(irq_o), 0);
        wr(A_EOS, 0);
        chk("R8 pop to empty", 32'(irq_o), 1);
        rd(A_VEC, vaddr(2), "R6 repeat");
        wr(A_EOS, 0);
        src_i[7] = 1'b0; src_i[2] = 1'b0; src_i[10] = 1'b0; cyc(2);
        chk("R6 idle", 32'(irq_o), 0);

        // R3 rising edge, internal
        wr(7'd8, 32'd11); wr(A_ENS, 32'h100);
        @(negedge clk); src_i[8] = 1'b1; @(negedge clk); src_i[8] = 1'b0; cyc(2);
        chk("R3 edge sticky", 32'(irq_o), 1);
        rd(A_VEC, vaddr(8), "R3 edge vec");
        wr(A_EOS, 0);
        chk("R3 edge cleared", 32'(irq_o), 0);

        // R3 falling edge on external source
        src_i[30] = 1'b1;
        wr(7'd30, 32'd29); wr(A_ENS, 32'h4000_0000); cyc(2);
        chk("R3 rise ignored falling", 32'(irq_o), 0);
        src_i[30] = 1'b0; cyc(3);
        chk("R3 falling edge", 32'(irq_o), 1);
        rd(A_VEC, vaddr(30), "R3 falling vec");
        wr(A_EOS, 0);

        // R2 low level external
        src_i[29] = 1'b1;
        wr(7'd29, 32'd17); wr(A_ENS, 32'h2000_0000); cyc(2);
        chk("R2 low level idle", 32'(irq_o), 0);
        src_i[29] = 1'b0; cyc(2);
        chk("R2 low level active", 32'(irq_o), 1);
        rd(A_VEC, vaddr(29), "R2 low vec");
        wr(A_EOS, 0); src_i[29] = 1'b1; cyc(2);

        // R4 inversion ignored on internal source
        wr(7'd4, 32'd18); wr(A_ENS, 32'h10); cyc(2);
        chk("R4 internal low ignored", 32'(irq_o), 0);
        src_i[4] = 1'b1; cyc(2);
        chk("R4 internal high", 32'(irq_o), 1);
        rd(A_VEC, vaddr(4), "R4 vec");
        wr(A_EOS, 0); src_i[4] = 1'b0; cyc(2);

        // R9 spurious re-pushes top
        wr(7'd6, 32'd3); wr(7'd9, 32'd2); wr(A_ENS, 32'h240);
        src_i[6] = 1'b1; cyc(2);
        rd(A_VEC, vaddr(6), "R9 setup");
        src_i[6] = 1'b0; cyc(2);
        rd(A_VEC, SPUR, "R9 spurious nested");
        wr(A_EOS, 0);
        src_i[9] = 1'b1; cyc(2);
        chk("R9 level kept after eos", 32'(irq_o), 0);
        wr(A_EOS, 0);
        chk("R9 stack empty", 32'(irq_o), 1);
        rd(A_VEC, vaddr(9), "R9 vec9");
        wr(A_EOS, 0); src_i[9] = 1'b0; cyc(2);

        // R11 depth limit
        wr(7'd11, 32'd0); wr(A_ENS, 32'h800); src_i[11] = 1'b1; cyc(2);
        rd(A_VEC, vaddr(11), "R11 first");
        for (int k = 0; k < 8; k++) rd(A_VEC, SPUR, "R11 spurious fill");
        for (int k = 0; k < 7; k++) wr(A_EOS, 0);
        chk("R11 one entry left", 32'(irq_o), 0);
        wr(A_EOS, 0);
        chk("R11 emptied after 8", 32'(irq_o), 1);
        rd(A_VEC, vaddr(11), "R11 final");
        wr(A_EOS, 0); src_i[11] = 1'b0; cyc(2);

        // R10 fast path
        @(negedge clk); fiq_i = 1'b1; @(negedge clk);
        chk("R10 fiq high", 32'(fiq_o), 1);
        chk("R10 irq untouched", 32'(irq_o), 0);
        fiq_i = 1'b0; @(negedge clk);
        chk("R10 fiq low", 32'(fiq_o), 0);

        cyc(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule